// File: doc/BRIEF.md
# Receive Descriptor Writer

This block lands incoming frames in memory under control of a ring of receive descriptors. Frames arrive one byte per beat on a valid/ready stream that marks its final byte with a last flag. When a frame starts and reception is enabled, the block reads the descriptor at the current ring pointer through a single-outstanding memory request port. It takes the ownership flag, the wrap flag and the buffer address from that descriptor. Each byte is then written to the buffer through a byte-lane write.

Once the final byte has been stored, the block decides the frame's outcome. A good frame gets a completion word written over the descriptor's first word: the length including four check bytes sits in the upper half, and the ownership flag goes back to software. The ring pointer then advances or wraps, and the statistics counters update. Short frames and frames that find no owned descriptor end differently. Each outcome raises its own one-cycle status pulses toward an interrupt/status block.

The destination address is classified from the first six bytes. Software programs the ring base through a load port, and that load also moves the current pointer.

Top module: `rx_desc_writer`

## Requirements
- R1: When `rx_start` is low at the first byte of a frame, the whole frame is consumed and dropped. No memory access, no status pulse, no counter change and no pointer change results.
- R2: A frame of fewer than 12 bytes raises `st_rx_int` and `st_norm_sum` together for one cycle. It leaves the descriptor, the ring pointer and all counters unchanged.
- R3: A frame of at least 12 bytes whose descriptor word 0 has bit 31 (own) clear raises `st_buf_unavail` and `st_abn_sum` for one cycle, without `st_rx_int`. Descriptor, pointer and counters stay unchanged.
- R4: A good frame of N bytes rewrites descriptor word 0 (byte offset 0) as ((N+4) << 16) | 0x300, so bit 31 ends clear.
- R5: After a good frame, the ring pointer becomes the ring base if bit 15 of descriptor word 1 (byte offset 4, buffer-1 size field) is set. Otherwise it advances by 32.
- R6: A frame is unicast if bit 0 of its first byte is clear. It is broadcast if its first six bytes are all 0xFF, and multicast otherwise.
- R7: Each good frame adds N+4 to `cnt_rx_bytes` and 1 to `cnt_rx_frames`. These counters change in the same cycle that `st_rx_int` is high.
- R8: Each good broadcast frame adds 1 to `cnt_rx_bcast`, and each good multicast frame adds 1 to `cnt_rx_mcast`. Unicast frames change neither.
- R9: Each good frame raises `st_rx_int` and `st_norm_sum` together for one cycle.
- R10: A pulse on `base_wr_en` loads `base_wr_data` into both the ring base and the current pointer on the next edge. It takes precedence over a pointer advance in the same cycle.
- R11: Byte k of a frame is written to the address in descriptor word 2 (byte offset 8) plus k. The write carries a one-hot `mem_be` selecting lane address[1:0] and the byte replicated on all four lanes.
- R12: A frame shorter than 12 bytes is reported as short (R2) even when its descriptor is not owned.
- R13: A memory request that is not granted stays asserted with unchanged address, direction and write data until it is granted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_start | input | 1 | Reception enable, sampled at the first byte of a frame |
| base_wr_en | input | 1 | Load pulse for the ring base |
| base_wr_data | input | ADDR_W | Ring base byte address |
| in_valid | input | 1 | Stream byte valid |
| in_data | input | 8 | Stream byte |
| in_last | input | 1 | Marks the final byte of a frame |
| in_ready | output | 1 | Stream byte accepted when high together with in_valid |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | ADDR_W | Byte address |
| mem_wdata | output | 32 | Write data |
| mem_be | output | 4 | Write byte lanes |
| mem_gnt | input | 1 | Request accepted this cycle |
| mem_rvalid | input | 1 | Read data valid (after a granted read) |
| mem_rdata | input | 32 | Read data |
| cur_desc_ptr | output | ADDR_W | Current descriptor pointer |
| st_rx_int | output | 1 | Receive-done pulse |
| st_norm_sum | output | 1 | Normal-summary pulse |
| st_buf_unavail | output | 1 | No-descriptor pulse |
| st_abn_sum | output | 1 | Abnormal-summary pulse |
| cnt_rx_bytes | output | CNT_W | Received byte count including check bytes |
| cnt_rx_frames | output | CNT_W | Good frame count |
| cnt_rx_mcast | output | CNT_W | Good multicast frame count |
| cnt_rx_bcast | output | CNT_W | Good broadcast frame count |

## Verification
A software load of the ring base can land on the same edge where a completed frame advances the ring pointer. The bench provokes this by granting every request at once and watching for the full-word completion write. In that very cycle it pulses `base_wr_en` with a new base. The load must win, so the pointer must equal the new base while the counters still record the frame. A following frame with its wrap flag set must then stay at that new base.

// File: rtl/rxdw_pkg.sv
package rxdw_pkg;

    // Descriptor field widths and positions fixed by the ring format
    localparam int LEN_W      = 16;
    localparam int WORD_W     = 32;
    localparam int OWN_BIT    = 31;
    localparam int WRAP_BIT   = 15;
    localparam int CRC_BYTES  = 4;
    localparam int DA_BYTES   = 6;
    localparam logic [15:0] DONE_FLAGS = 16'h0300;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_FETCH_CTL,
        ST_FETCH_SIZE,
        ST_FETCH_BUF,
        ST_STREAM,
        ST_DRAIN,
        ST_WRITEBACK,
        ST_DISCARD
    } rxdw_state_e;

    typedef enum logic [1:0] {
        CLS_UNI,
        CLS_BCAST,
        CLS_MCAST
    } frame_class_e;

    typedef struct packed {
        logic rx_int;
        logic norm_sum;
        logic buf_unavail;
        logic abn_sum;
    } rx_status_t;

    typedef struct packed {
        logic             busy;
        logic [7:0]       data;
        logic [LEN_W-1:0] off;
    } pend_byte_t;

    function automatic logic [3:0] byte_lane(input logic [1:0] a);
        return 4'b0001 << a;
    endfunction

    function automatic logic [WORD_W-1:0] done_word(input logic [LEN_W-1:0] len);
        logic [LEN_W-1:0] total;
        total = len + LEN_W'(CRC_BYTES);
        return {total, DONE_FLAGS};
    endfunction

endpackage

// File: rtl/rxdw_da_class.sv
module rxdw_da_class
    import rxdw_pkg::*;
#(
    parameter int IDX_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clear,
    input  logic             byte_en,
    input  logic [IDX_W-1:0] idx,
    input  logic [7:0]       byte_in,
    output frame_class_e     cls
);

    logic group_q;
    logic all_ones_q;

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            group_q    <= 1'b0;
            all_ones_q <= 1'b1;
        end else if (byte_en && (idx < IDX_W'(DA_BYTES))) begin
            if (idx == '0) begin
                group_q <= byte_in[0];
            end
            all_ones_q <= all_ones_q && (byte_in == 8'hFF);
        end
    end

    always_comb begin
        if (!group_q) begin
            cls = CLS_UNI;
        end else if (all_ones_q) begin
            cls = CLS_BCAST;
        end else begin
            cls = CLS_MCAST;
        end
    end

endmodule

// File: rtl/rxdw_stats.sv
module rxdw_stats
    import rxdw_pkg::*;
#(
    parameter int CNT_W = 64
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             bump,
    input  logic [LEN_W-1:0] add_bytes,
    input  frame_class_e     cls,
    output logic [CNT_W-1:0] bytes_cnt,
    output logic [CNT_W-1:0] frames_cnt,
    output logic [CNT_W-1:0] mcast_cnt,
    output logic [CNT_W-1:0] bcast_cnt
);

    localparam int NUM_EVT = 3;

    logic [NUM_EVT-1:0] hit;
    logic [CNT_W-1:0]   evt_cnt [NUM_EVT];
    logic [CNT_W-1:0]   bytes_q;

    assign hit[0] = bump;
    assign hit[1] = bump && (cls == CLS_MCAST);
    assign hit[2] = bump && (cls == CLS_BCAST);

    // Counters wrap at their width; no saturation
    for (genvar gi = 0; gi < NUM_EVT; gi++) begin : g_evt
        logic [CNT_W-1:0] cnt_q;
        always_ff @(posedge clk) begin
            if (rst) begin
                cnt_q <= '0;
            end else if (hit[gi]) begin
                cnt_q <= cnt_q + CNT_W'(1);
            end
        end
        assign evt_cnt[gi] = cnt_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            bytes_q <= '0;
        end else if (bump) begin
            bytes_q <= bytes_q + CNT_W'(add_bytes) + CNT_W'(CRC_BYTES);
        end
    end

    assign bytes_cnt  = bytes_q;
    assign frames_cnt = evt_cnt[0];
    assign mcast_cnt  = evt_cnt[1];
    assign bcast_cnt  = evt_cnt[2];

endmodule

// File: rtl/rxdw_ring_ptr.sv
module rxdw_ring_ptr #(
    parameter int ADDR_W = 32,
    parameter int STEP   = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [ADDR_W-1:0] load_val,
    input  logic              advance,
    input  logic              wrap,
    output logic [ADDR_W-1:0] base,
    output logic [ADDR_W-1:0] cur
);

    logic [ADDR_W-1:0] base_q;
    logic [ADDR_W-1:0] cur_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            base_q <= '0;
            cur_q  <= '0;
        end else if (load) begin
            // software load wins over a same-cycle advance
            base_q <= load_val;
            cur_q  <= load_val;
        end else if (advance) begin
            cur_q <= wrap ? base_q : cur_q + ADDR_W'(STEP);
        end
    end

    assign base = base_q;
    assign cur  = cur_q;

endmodule

// File: rtl/rx_desc_writer.sv
module rx_desc_writer
    import rxdw_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int CNT_W      = 64,
    parameter int MIN_LEN    = 12,
    parameter int DESC_BYTES = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rx_start,
    input  logic              base_wr_en,
    input  logic [ADDR_W-1:0] base_wr_data,
    input  logic              in_valid,
    input  logic [7:0]        in_data,
    input  logic              in_last,
    output logic              in_ready,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [31:0]       mem_wdata,
    output logic [3:0]        mem_be,
    input  logic              mem_gnt,
    input  logic              mem_rvalid,
    input  logic [31:0]       mem_rdata,
    output logic [ADDR_W-1:0] cur_desc_ptr,
    output logic              st_rx_int,
    output logic              st_norm_sum,
    output logic              st_buf_unavail,
    output logic              st_abn_sum,
    output logic [CNT_W-1:0]  cnt_rx_bytes,
    output logic [CNT_W-1:0]  cnt_rx_frames,
    output logic [CNT_W-1:0]  cnt_rx_mcast,
    output logic [CNT_W-1:0]  cnt_rx_bcast
);

    localparam int OFF_SIZE = 4;
    localparam int OFF_BUF  = 8;

    rxdw_state_e       state_q;
    logic              own_q;
    logic              wrap_q;
    logic              rd_wait_q;
    logic [ADDR_W-1:0] buf_q;
    logic [LEN_W-1:0]  len_q;
    pend_byte_t        pend_q;
    rx_status_t        status_q;
    rx_status_t        status_d;

    logic              accept;
    logic              mem_fire;
    logic              end_check;
    logic              runt_end;
    logic              nodesc_end;
    logic              good_end;
    logic [ADDR_W-1:0] ring_base;
    frame_class_e      frame_cls;

    assign accept   = in_valid && in_ready;
    assign mem_fire = mem_req && mem_gnt;

    assign in_ready = ((state_q == ST_STREAM) && !pend_q.busy) || (state_q == ST_DISCARD);

    // Outcome decode once the last byte write has drained
    assign end_check  = (state_q == ST_DRAIN) && !pend_q.busy;
    assign runt_end   = end_check && (len_q < LEN_W'(MIN_LEN));
    assign nodesc_end = end_check && !runt_end && !own_q;
    assign good_end   = (state_q == ST_WRITEBACK) && mem_fire;

    always_comb begin
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = '0;
        mem_wdata = '0;
        mem_be    = 4'h0;
        case (state_q)
            ST_FETCH_CTL: begin
                mem_req  = !rd_wait_q;
                mem_addr = cur_desc_ptr;
                mem_be   = 4'hF;
            end
            ST_FETCH_SIZE: begin
                mem_req  = !rd_wait_q;
                mem_addr = cur_desc_ptr + ADDR_W'(OFF_SIZE);
                mem_be   = 4'hF;
            end
            ST_FETCH_BUF: begin
                mem_req  = !rd_wait_q;
                mem_addr = cur_desc_ptr + ADDR_W'(OFF_BUF);
                mem_be   = 4'hF;
            end
            ST_STREAM, ST_DRAIN: begin
                mem_req   = pend_q.busy;
                mem_we    = 1'b1;
                mem_addr  = buf_q + ADDR_W'(pend_q.off);
                mem_wdata = {4{pend_q.data}};
                mem_be    = byte_lane(mem_addr[1:0]);
            end
            ST_WRITEBACK: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = cur_desc_ptr;
                mem_wdata = done_word(len_q);
                mem_be    = 4'hF;
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q   <= ST_IDLE;
            own_q     <= 1'b0;
            wrap_q    <= 1'b0;
            rd_wait_q <= 1'b0;
            buf_q     <= '0;
            len_q     <= '0;
            pend_q    <= '0;
        end else begin
            case (state_q)
                ST_IDLE: begin
                    if (in_valid) begin
                        state_q <= rx_start ? ST_FETCH_CTL : ST_DISCARD;
                        len_q   <= '0;
                        own_q   <= 1'b0;
                        wrap_q  <= 1'b0;
                    end
                end
                ST_FETCH_CTL: begin
                    if (mem_rvalid) begin
                        rd_wait_q <= 1'b0;
                        own_q     <= mem_rdata[OWN_BIT];
                        // an unowned descriptor skips the remaining reads
                        state_q   <= mem_rdata[OWN_BIT] ? ST_FETCH_SIZE : ST_STREAM;
                    end else if (mem_fire) begin
                        rd_wait_q <= 1'b1;
                    end
                end
                ST_FETCH_SIZE: begin
                    if (mem_rvalid) begin
                        rd_wait_q <= 1'b0;
                        wrap_q    <= mem_rdata[WRAP_BIT];
                        state_q   <= ST_FETCH_BUF;
                    end else if (mem_fire) begin
                        rd_wait_q <= 1'b1;
                    end
                end
                ST_FETCH_BUF: begin
                    if (mem_rvalid) begin
                        rd_wait_q <= 1'b0;
                        buf_q     <= mem_rdata[ADDR_W-1:0];
                        state_q   <= ST_STREAM;
                    end else if (mem_fire) begin
                        rd_wait_q <= 1'b1;
                    end
                end
                ST_STREAM: begin
                    if (mem_fire) begin
                        pend_q.busy <= 1'b0;
                    end
                    if (accept) begin
                        len_q <= len_q + LEN_W'(1);
                        if (own_q) begin
                            pend_q.busy <= 1'b1;
                            pend_q.data <= in_data;
                            pend_q.off  <= len_q;
                        end
                        if (in_last) begin
                            state_q <= ST_DRAIN;
                        end
                    end
                end
                ST_DRAIN: begin
                    if (mem_fire) begin
                        pend_q.busy <= 1'b0;
                    end
                    if (end_check) begin
                        state_q <= (runt_end || nodesc_end) ? ST_IDLE : ST_WRITEBACK;
                    end
                end
                ST_WRITEBACK: begin
                    if (mem_fire) begin
                        state_q <= ST_IDLE;
                    end
                end
                ST_DISCARD: begin
                    if (accept && in_last) begin
                        state_q <= ST_IDLE;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    always_comb begin
        status_d.rx_int      = runt_end || good_end;
        status_d.norm_sum    = runt_end || good_end;
        status_d.buf_unavail = nodesc_end;
        status_d.abn_sum     = nodesc_end;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            status_q <= '0;
        end else begin
            status_q <= status_d;
        end
    end

    assign st_rx_int      = status_q.rx_int;
    assign st_norm_sum    = status_q.norm_sum;
    assign st_buf_unavail = status_q.buf_unavail;
    assign st_abn_sum     = status_q.abn_sum;

    rxdw_da_class #(
        .IDX_W (LEN_W)
    ) u_class (
        .clk     (clk),
        .rst     (rst),
        .clear   ((state_q == ST_IDLE) && in_valid),
        .byte_en (accept && (state_q == ST_STREAM)),
        .idx     (len_q),
        .byte_in (in_data),
        .cls     (frame_cls)
    );

    rxdw_stats #(
        .CNT_W (CNT_W)
    ) u_stats (
        .clk        (clk),
        .rst        (rst),
        .bump       (good_end),
        .add_bytes  (len_q),
        .cls        (frame_cls),
        .bytes_cnt  (cnt_rx_bytes),
        .frames_cnt (cnt_rx_frames),
        .mcast_cnt  (cnt_rx_mcast),
        .bcast_cnt  (cnt_rx_bcast)
    );

    rxdw_ring_ptr #(
        .ADDR_W (ADDR_W),
        .STEP   (DESC_BYTES)
    ) u_ptr (
        .clk      (clk),
        .rst      (rst),
        .load     (base_wr_en),
        .load_val (base_wr_data),
        .advance  (good_end),
        .wrap     (wrap_q),
        .base     (ring_base),
        .cur      (cur_desc_ptr)
    );

endmodule

// File: rtl/rx_desc_writer_chk.sv
module rx_desc_writer_chk #(
    parameter int ADDR_W     = 32,
    parameter int CNT_W      = 64,
    parameter int DESC_BYTES = 32
) (
    input logic              clk,
    input logic              rst,
    input logic              base_wr_en,
    input logic [ADDR_W-1:0] base_wr_data,
    input logic              mem_req,
    input logic              mem_we,
    input logic [ADDR_W-1:0] mem_addr,
    input logic [31:0]       mem_wdata,
    input logic [3:0]        mem_be,
    input logic              mem_gnt,
    input logic [ADDR_W-1:0] cur_desc_ptr,
    input logic [ADDR_W-1:0] ring_base,
    input logic              st_rx_int,
    input logic              st_norm_sum,
    input logic              st_buf_unavail,
    input logic              st_abn_sum,
    input logic [CNT_W-1:0]  cnt_rx_frames
);

    p_done_pair_r9: assert property (@(posedge clk) disable iff (rst)
        st_rx_int |-> st_norm_sum);

    p_unavail_pair_r3: assert property (@(posedge clk) disable iff (rst)
        st_buf_unavail |-> (st_abn_sum && !st_rx_int));

    p_req_hold_r13: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_gnt) |=> (mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata)));

    p_byte_lane_r11: assert property (@(posedge clk) disable iff (rst)
        (mem_req && mem_we && (mem_be != 4'hF)) |-> (mem_be == (4'b0001 << mem_addr[1:0])));

    p_base_load_r10: assert property (@(posedge clk) disable iff (rst)
        base_wr_en |=> ((cur_desc_ptr == $past(base_wr_data)) && (ring_base == $past(base_wr_data))));

    p_ptr_step_r5: assert property (@(posedge clk) disable iff (rst)
        (!$past(base_wr_en) && !$stable(cur_desc_ptr)) |->
            ((cur_desc_ptr == $past(cur_desc_ptr) + ADDR_W'(DESC_BYTES)) || (cur_desc_ptr == ring_base)));

    p_frame_step_r7: assert property (@(posedge clk) disable iff (rst)
        !$stable(cnt_rx_frames) |-> ((cnt_rx_frames == $past(cnt_rx_frames) + CNT_W'(1)) && st_rx_int));

endmodule

bind rx_desc_writer rx_desc_writer_chk #(
    .ADDR_W     (ADDR_W),
    .CNT_W      (CNT_W),
    .DESC_BYTES (DESC_BYTES)
) chk_i (
    .clk            (clk),
    .rst            (rst),
    .base_wr_en     (base_wr_en),
    .base_wr_data   (base_wr_data),
    .mem_req        (mem_req),
    .mem_we         (mem_we),
    .mem_addr       (mem_addr),
    .mem_wdata      (mem_wdata),
    .mem_be         (mem_be),
    .mem_gnt        (mem_gnt),
    .cur_desc_ptr   (cur_desc_ptr),
    .ring_base      (ring_base),
    .st_rx_int      (st_rx_int),
    .st_norm_sum    (st_norm_sum),
    .st_buf_unavail (st_buf_unavail),
    .st_abn_sum     (st_abn_sum),
    .cnt_rx_frames  (cnt_rx_frames)
);

// File: tb/rx_desc_writer_tb_top.sv
module rx_desc_writer_tb_top;

    localparam int AW = 32;
    localparam int CW = 64;

    typedef struct packed {
        logic       en;
        logic       own;
        logic       wrap;
        logic [1:0] kind;   // 0 unicast, 1 broadcast, 2 multicast
        logic [7:0] len;
    } vec_t;

    localparam int NV = 10;
    localparam vec_t VECS [0:NV-1] = '{
        '{1'b1, 1'b1, 1'b0, 2'd0, 8'd20},
        '{1'b1, 1'b1, 1'b0, 2'd1, 8'd64},
        '{1'b1, 1'b1, 1'b0, 2'd2, 8'd12},
        '{1'b1, 1'b1, 1'b0, 2'd0, 8'd11},
        '{1'b1, 1'b0, 1'b0, 2'd2, 8'd30},
        '{1'b1, 1'b0, 1'b0, 2'd0, 8'd5},
        '{1'b0, 1'b1, 1'b0, 2'd1, 8'd40},
        '{1'b1, 1'b1, 1'b1, 2'd2, 8'd33},
        '{1'b1, 1'b1, 1'b0, 2'd1, 8'd13},
        '{1'b1, 1'b1, 1'b0, 2'd0, 8'd100}
    };

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #2.5 clk = ~clk;

    logic          rx_start = 1'b0;
    logic          base_wr_en = 1'b0;
    logic [AW-1:0] base_wr_data = '0;
    logic          in_valid = 1'b0;
    logic [7:0]    in_data = 8'h00;
    logic          in_last = 1'b0;
    logic          in_ready;
    logic          mem_req, mem_we, mem_gnt;
    logic [AW-1:0] mem_addr;
    logic [31:0]   mem_wdata;
    logic [3:0]    mem_be;
    logic          mem_rvalid = 1'b0;
    logic [31:0]   mem_rdata = '0;
    logic [AW-1:0] cur_desc_ptr;
    logic          st_rx_int, st_norm_sum, st_buf_unavail, st_abn_sum;
    logic [CW-1:0] cnt_rx_bytes, cnt_rx_frames, cnt_rx_mcast, cnt_rx_bcast;

    rx_desc_writer dut_i (
        .clk(clk), .rst(rst), .rx_start(rx_start),
        .base_wr_en(base_wr_en), .base_wr_data(base_wr_data),
        .in_valid(in_valid), .in_data(in_data), .in_last(in_last), .in_ready(in_ready),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_be(mem_be), .mem_gnt(mem_gnt), .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata),
        .cur_desc_ptr(cur_desc_ptr),
        .st_rx_int(st_rx_int), .st_norm_sum(st_norm_sum),
        .st_buf_unavail(st_buf_unavail), .st_abn_sum(st_abn_sum),
        .cnt_rx_bytes(cnt_rx_bytes), .cnt_rx_frames(cnt_rx_frames),
        .cnt_rx_mcast(cnt_rx_mcast), .cnt_rx_bcast(cnt_rx_bcast)
    );

    // Memory model: grant with pseudo-random stalls, read data one cycle later
    logic [7:0]  mem [0:4095] = '{default: 8'h00};
    logic [7:0]  lfsr = 8'h5A;
    logic        stall_en = 1'b0;
    logic        hw_en = 1'b0;
    logic [11:0] hw_a = '0;
    logic [31:0] hw_d = '0;

    assign mem_gnt = mem_req && !(stall_en && lfsr[0]);

    always @(posedge clk) begin
        lfsr       <= {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
        mem_rvalid <= 1'b0;
        if (hw_en) begin
            for (int b = 0; b < 4; b++) mem[hw_a + 12'(b)] <= hw_d[8*b +: 8];
        end
        if (mem_req && mem_gnt) begin
            if (mem_we) begin
                for (int b = 0; b < 4; b++)
                    if (mem_be[b]) mem[{mem_addr[11:2], 2'(b)}] <= mem_wdata[8*b +: 8];
            end else begin
                mem_rvalid <= 1'b1;
                mem_rdata  <= {mem[{mem_addr[11:2], 2'd3}], mem[{mem_addr[11:2], 2'd2}],
                               mem[{mem_addr[11:2], 2'd1}], mem[{mem_addr[11:2], 2'd0}]};
            end
        end
    end

    // Sticky status capture and request-hold tracking
    logic       clr_seen = 1'b0;
    logic [3:0] seen = '0;
    logic       prev_stall = 1'b0;
    logic [AW-1:0] prev_addr = '0;
    int         hold_viol = 0;

    always @(posedge clk) begin
        if (clr_seen) seen <= '0;
        else seen <= seen | {st_rx_int, st_norm_sum, st_buf_unavail, st_abn_sum};
        if (!rst && prev_stall && (!mem_req || mem_addr != prev_addr)) hold_viol++;
        prev_stall <= mem_req && !mem_gnt;
        prev_addr  <= mem_addr;
    end

    int n_chk  = 0;
    int n_fail = 0;

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] rd32(input int a);
        return {mem[a+3], mem[a+2], mem[a+1], mem[a]};
    endfunction

    task automatic host_wr32(input int a, input logic [31:0] d);
        @(negedge clk);
        hw_en = 1'b1; hw_a = 12'(a); hw_d = d;
        @(negedge clk);
        hw_en = 1'b0;
    endtask

    function automatic logic [7:0] frame_byte(input int idx, input int k, input int kind);
        if (k < 6) begin
            if (kind == 1) return 8'hFF;
            if (k == 0) return (kind == 2) ? 8'h01 : 8'h02;
            return 8'(8'h30 + k);
        end
        return 8'(idx * 16 + k);
    endfunction

    logic [AW-1:0] exp_ptr = '0;
    logic [AW-1:0] exp_base = '0;
    logic [CW-1:0] exp_bytes = '0, exp_frames = '0, exp_mc = '0, exp_bc = '0;

    task automatic send_frame(input int idx, input int len, input int kind);
        for (int k = 0; k < len; k++) begin
            @(negedge clk);
            in_valid = 1'b1;
            in_data  = frame_byte(idx, k, kind);
            in_last  = (k == len - 1);
            while (!in_ready) @(negedge clk);
        end
        @(negedge clk);
        in_valid = 1'b0;
        in_last  = 1'b0;
    endtask

    task automatic race_base(input logic [AW-1:0] nb);
        @(negedge clk);
        while (!(mem_req && mem_we && mem_be == 4'hF)) @(negedge clk);
        base_wr_en = 1'b1; base_wr_data = nb;
        @(negedge clk);
        base_wr_en = 1'b0;
    endtask

    task automatic run_frame(input int idx, input vec_t v, input int bufa,
                             input bit race, input logic [AW-1:0] race_val);
        logic [31:0] w0_before, w0_exp;
        bit good, runt, nodesc;
        string lab;
        w0_before = v.own ? 32'h8000_0000 : 32'h0;
        host_wr32(int'(exp_ptr), w0_before);
        host_wr32(int'(exp_ptr) + 4, (v.wrap ? 32'h8000 : 32'h0) | 32'd1536);
        host_wr32(int'(exp_ptr) + 8, 32'(bufa));
        host_wr32(bufa, 32'h0);
        @(negedge clk);
        clr_seen = 1'b1; rx_start = v.en;
        @(negedge clk);
        clr_seen = 1'b0;
        if (race) begin
            fork
                send_frame(idx, int'(v.len), int'(v.kind));
                race_base(race_val);
            join
        end else begin
            send_frame(idx, int'(v.len), int'(v.kind));
        end
        repeat (40) @(negedge clk);

        runt   = v.en && (v.len < 12);
        nodesc = v.en && (v.len >= 12) && !v.own;
        good   = v.en && (v.len >= 12) && v.own;
        lab    = !v.en ? "R1" : runt ? (v.own ? "R2" : "R12") : nodesc ? "R3" : "R9";
        w0_exp = good ? ((32'(v.len) + 32'd4) << 16) | 32'h300 : w0_before;
        if (good) begin
            exp_bytes  += CW'(v.len) + 4;
            exp_frames += 1;
            if (v.kind == 2'd1) exp_bc += 1;
            if (v.kind == 2'd2) exp_mc += 1;
        end
        check({lab, " ri"},  seen[3], good || runt);
        check({lab, " nis"}, seen[2], good || runt);
        check({lab, " ru"},  seen[1], nodesc);
        check({lab, " ais"}, seen[0], nodesc);
        check(good ? "R4 word0" : {lab, " word0"}, rd32(int'(exp_ptr)), w0_exp);
        if (race) begin
            exp_ptr  = race_val;
            exp_base = race_val;
            check("R10 race ptr", cur_desc_ptr, exp_ptr);
        end else begin
            if (good) exp_ptr = v.wrap ? exp_base : exp_ptr + 32;
            check(good ? "R5 ptr" : {lab, " ptr"}, cur_desc_ptr, exp_ptr);
        end
        check(good ? "R7 frames" : {lab, " frames"}, cnt_rx_frames, exp_frames);
        check(good ? "R7 bytes" : {lab, " bytes"}, cnt_rx_bytes, exp_bytes);
        check(good ? "R8 R6 mcast" : {lab, " mcast"}, cnt_rx_mcast, exp_mc);
        check(good ? "R8 R6 bcast" : {lab, " bcast"}, cnt_rx_bcast, exp_bc);
        if (good) begin
            check("R11 first byte", 64'(mem[bufa]), 64'(frame_byte(idx, 0, int'(v.kind))));
            check("R11 last byte", 64'(mem[bufa + int'(v.len) - 1]),
                  64'(frame_byte(idx, int'(v.len) - 1, int'(v.kind))));
        end
        if (!v.en) check("R1 buffer untouched", 64'(rd32(bufa)), 64'h0);
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // Reset state
        check("R10 reset ptr", cur_desc_ptr, 0);
        check("R7 reset frames", cnt_rx_frames, 0);
        check("R7 reset bytes", cnt_rx_bytes, 0);
        check("R9 reset status", 64'({st_rx_int, st_norm_sum, st_buf_unavail, st_abn_sum}), 0);
        check("R1 reset ready", 64'(in_ready), 0);

        // Ring base load
        base_wr_en = 1'b1; base_wr_data = 32'h100;
        @(negedge clk);
        base_wr_en = 1'b0;
        exp_ptr = 32'h100; exp_base = 32'h100;
        check("R10 base load", cur_desc_ptr, exp_ptr);

        // Vector table with random grant stalls
        stall_en = 1'b1;
        for (int i = 0; i < NV; i++) begin
            run_frame(i, VECS[i], 32'h800 + i * 32'h80, 1'b0, '0);
        end

        // Base load on the same edge as the pointer advance
        stall_en = 1'b0;
        run_frame(11, '{1'b1, 1'b1, 1'b0, 2'd2, 8'd16}, 32'hE00, 1'b1, 32'h380);
        // Following frame wraps to the newly loaded base
        run_frame(12, '{1'b1, 1'b1, 1'b1, 2'd0, 8'd24}, 32'hE80, 1'b0, '0);
        check("R10 base after race", cur_desc_ptr, 32'h380);

        check("R13 request hold", 64'(hold_viol), 0);
        finish_run();
    end

endmodule